// File: doc/BRIEF.md
# Deferred error syndrome register unit

This unit holds a 64-bit system register that records an asynchronous error which an error-synchronization barrier has deferred. When the barrier defers a pending error, the unit sets a pending flag and stores a syndrome. The syndrome is kept either as architected sub-fields (error type, external-abort type, fault status code) or as a raw 24-bit implementation-defined word. A format bit selects which of the two applies.

The unit also decodes privileged register-access requests. A request that hits the register's encoding is routed by the current exception level. Level 0 traps as an undefined instruction. At level 1, the request is redirected to a separate virtual copy of the register when the hypervisor is enabled and it routes aborts to itself. In every other case the request targets the physical register. When a secure monitor exists, the core is outside debug state and the monitor routes external aborts to itself, physical accesses at the levels selected by a mask input read as zero and drop their writes.

Read data is a combinational function of the stored state and the request. A barrier capture is therefore visible to a read in the very next cycle.

Top module: `dsyn_reg_unit`

## Requirements
- R1: Only requests whose 16-bit encoding {op0,op1,CRn,CRm,op2} equals 0xC609 (op0=3, op1=0, CRn=12, CRm=1, op2=1) are served. Any other encoding raises no trap, does not assert `virt_sel`, returns zero and leaves the register unchanged.
- R2: A matching request at level 0 asserts `undef_trap`, returns zero, and leaves the register unchanged even when it is a write.
- R3: At level 1 with `hyp_enabled` and `hyp_abort_route` both 1, `virt_sel` is 1, reads return `virt_rdata`, and writes leave the physical register unchanged.
- R4: At level 1 without both hypervisor bits set, and at levels 2 and 3, requests read and write the physical register, and `virt_sel` is 0.
- R5: When `mon_present`=1, `in_debug`=0, `mon_ea_route`=1 and `razwi_el_mask[level]`=1, a physical-target request reads as zero and its write is dropped. Clearing `in_debug` to 0 is required for this; with `in_debug`=1 the access is normal.
- R6: A barrier event (`defer_valid`) sets bit 31 and loads bit 24 from `defer_impl`. A read in the next cycle returns the new value.
- R7: With bit 24 = 0, only bits 12:10 (error type), bit 9 (external-abort type) and bits 5:0 (fault status code) of the syndrome are stored. Bits 23:13 and 8:6 read as zero.
- R8: With bit 24 = 1, bits 23:0 store the full 24-bit syndrome.
- R9: Bits 63:32 and 30:25 of the physical register always read as zero. Software writes drop them.
- R10: When a barrier event and a software write arrive in the same cycle, the barrier's value is stored.
- R11: With parameter `HAS_SYNC_SRC`=0, bit 31 always reads as zero, both after software writes and after barrier events.
- R12: `rd_data` is zero whenever no read is being served, including during writes and when no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| defer_valid | input | 1 | Barrier deferred a pending error this cycle |
| defer_impl | input | 1 | Syndrome format of the deferred error (1 = implementation-defined) |
| defer_syn | input | 24 | Syndrome of the deferred error |
| acc_valid | input | 1 | Register-access request present |
| acc_enc | input | 16 | Request encoding {op0,op1,CRn,CRm,op2} |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 64 | Write data |
| acc_el | input | 2 | Current exception level |
| hyp_enabled | input | 1 | Hypervisor level enabled |
| hyp_abort_route | input | 1 | Hypervisor routes aborts to itself |
| mon_present | input | 1 | Secure-monitor level exists |
| mon_ea_route | input | 1 | Monitor routes external aborts to itself |
| in_debug | input | 1 | Core is in debug state |
| razwi_el_mask | input | 4 | Levels at which monitor routing makes the register read-as-zero |
| virt_rdata | input | 64 | Current value of the virtual copy |
| rd_data | output | 64 | Read data |
| undef_trap | output | 1 | Undefined-instruction trap |
| virt_sel | output | 1 | Request is steered to the virtual copy |

## Verification
Write-then-read patterns with the format bit at 0 and 1, all-ones and all-zeros words, and scattered reserved bits show whether the stored layout masks exactly the right bits for each format. The same request is then repeated at each level and under every combination of hypervisor routing, monitor routing and debug state. This separates trapping, virtual steering, read-as-zero and plain physical access, because the register holds a known non-zero value that only a real physical read returns. Barrier events followed at once by a read test next-cycle visibility. A barrier colliding with a write shows which of the two wins. A second instance without synchronizable sources confirms that bit 31 stays clear.

// File: rtl/dsyn_pkg.sv
package dsyn_pkg;

    localparam int REG_W = 64;
    localparam int SYN_W = 24;
    localparam int ENC_W = 16;
    localparam int EL_W  = 2;
    localparam int NUM_EL = 1 << EL_W;

    // {op0, op1, CRn, CRm, op2} = {2'b11, 3'b000, 4'b1100, 4'b0001, 3'b001}
    localparam logic [ENC_W-1:0] DSYN_ENC = 16'hC609;

    typedef enum logic [2:0] {
        RT_IDLE,
        RT_UNDEF,
        RT_PHYS,
        RT_VIRT,
        RT_RAZWI
    } route_e;

    typedef struct packed {
        logic             pend;
        logic             impl_fmt;
        logic [SYN_W-1:0] syn;
    } dsyn_state_t;

    // Keep only the bits the chosen format defines.
    function automatic logic [SYN_W-1:0] keep_syn(input logic impl,
                                                  input logic [SYN_W-1:0] raw);
        logic [SYN_W-1:0] k;
        if (impl) begin
            k = raw;
        end else begin
            k        = '0;
            k[12:10] = raw[12:10];
            k[9]     = raw[9];
            k[5:0]   = raw[5:0];
        end
        return k;
    endfunction

endpackage

// File: rtl/dsyn_route.sv
module dsyn_route
    import dsyn_pkg::*;
(
    input  logic               acc_valid,
    input  logic [ENC_W-1:0]   acc_enc,
    input  logic [EL_W-1:0]    acc_el,
    input  logic               hyp_enabled,
    input  logic               hyp_abort_route,
    input  logic               mon_present,
    input  logic               mon_ea_route,
    input  logic               in_debug,
    input  logic [NUM_EL-1:0]  razwi_el_mask,
    output route_e             route
);

    logic hit;
    logic razwi_on;

    always_comb begin
        hit      = acc_valid && (acc_enc == DSYN_ENC);
        razwi_on = mon_present && !in_debug && mon_ea_route && razwi_el_mask[acc_el];
        if (!hit) begin
            route = RT_IDLE;
        end else if (acc_el == EL_W'(0)) begin
            route = RT_UNDEF;
        end else if (acc_el == EL_W'(1) && hyp_enabled && hyp_abort_route) begin
            route = RT_VIRT;
        end else if (razwi_on) begin
            route = RT_RAZWI;
        end else begin
            route = RT_PHYS;
        end
    end

endmodule

// File: rtl/dsyn_store.sv
module dsyn_store
    import dsyn_pkg::*;
#(
    parameter bit HAS_SYNC_SRC = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               defer_valid,
    input  logic               defer_impl,
    input  logic [SYN_W-1:0]   defer_syn,
    input  logic               sw_we,
    input  logic [REG_W-1:0]   sw_wdata,
    output dsyn_state_t        state_q
);

    localparam int PEND_BIT = 31;
    localparam int FMT_BIT  = 24;

    dsyn_state_t nxt;
    dsyn_state_t state_d;

    always_comb begin
        nxt = state_q;
        if (defer_valid) begin
            nxt.pend     = 1'b1;
            nxt.impl_fmt = defer_impl;
            nxt.syn      = keep_syn(defer_impl, defer_syn);
        end else if (sw_we) begin
            nxt.pend     = sw_wdata[PEND_BIT];
            nxt.impl_fmt = sw_wdata[FMT_BIT];
            nxt.syn      = keep_syn(sw_wdata[FMT_BIT], sw_wdata[SYN_W-1:0]);
        end
    end

    generate
        if (HAS_SYNC_SRC) begin : g_pend
            always_comb state_d = nxt;
        end else begin : g_no_pend
            always_comb begin
                state_d      = nxt;
                state_d.pend = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/dsyn_reg_unit.sv
module dsyn_reg_unit
    import dsyn_pkg::*;
#(
    parameter bit HAS_SYNC_SRC = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               defer_valid,
    input  logic               defer_impl,
    input  logic [23:0]        defer_syn,
    input  logic               acc_valid,
    input  logic [15:0]        acc_enc,
    input  logic               acc_write,
    input  logic [63:0]        acc_wdata,
    input  logic [1:0]         acc_el,
    input  logic               hyp_enabled,
    input  logic               hyp_abort_route,
    input  logic               mon_present,
    input  logic               mon_ea_route,
    input  logic               in_debug,
    input  logic [3:0]         razwi_el_mask,
    input  logic [63:0]        virt_rdata,
    output logic [63:0]        rd_data,
    output logic               undef_trap,
    output logic               virt_sel
);

    route_e      route;
    dsyn_state_t state_q;
    logic        sw_we;
    logic [REG_W-1:0] phys_word;

    dsyn_route u_route (
        .acc_valid       (acc_valid),
        .acc_enc         (acc_enc),
        .acc_el          (acc_el),
        .hyp_enabled     (hyp_enabled),
        .hyp_abort_route (hyp_abort_route),
        .mon_present     (mon_present),
        .mon_ea_route    (mon_ea_route),
        .in_debug        (in_debug),
        .razwi_el_mask   (razwi_el_mask),
        .route           (route)
    );

    assign sw_we = (route == RT_PHYS) && acc_write;

    dsyn_store #(
        .HAS_SYNC_SRC (HAS_SYNC_SRC)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .defer_valid (defer_valid),
        .defer_impl  (defer_impl),
        .defer_syn   (defer_syn),
        .sw_we       (sw_we),
        .sw_wdata    (acc_wdata),
        .state_q     (state_q)
    );

    always_comb begin
        phys_word = {32'b0, state_q.pend, 6'b0, state_q.impl_fmt, state_q.syn};
        rd_data   = '0;
        if (!acc_write) begin
            if (route == RT_PHYS) begin
                rd_data = phys_word;
            end else if (route == RT_VIRT) begin
                rd_data = virt_rdata;
            end
        end
        undef_trap = (route == RT_UNDEF);
        virt_sel   = (route == RT_VIRT);
    end

endmodule

// File: rtl/dsyn_reg_unit_chk.sv
module dsyn_reg_unit_chk
    import dsyn_pkg::*;
#(
    parameter bit HAS_SYNC_SRC = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         acc_valid,
    input logic [15:0]  acc_enc,
    input logic [1:0]   acc_el,
    input logic         hyp_enabled,
    input logic         hyp_abort_route,
    input logic         defer_valid,
    input logic [63:0]  rd_data,
    input logic         undef_trap,
    input logic         virt_sel,
    input dsyn_state_t  state_q
);

    logic hit;
    assign hit = acc_valid && (acc_enc == DSYN_ENC);

    p_other_enc_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_enc != DSYN_ENC) |-> (!undef_trap && !virt_sel && rd_data == '0));

    p_el0_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && acc_el == 2'd0) |-> (undef_trap && rd_data == '0));

    p_el0_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && acc_el == 2'd0 && !defer_valid) |=> $stable(state_q));

    p_virt_only_el1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        virt_sel |-> (acc_el == 2'd1 && hyp_enabled && hyp_abort_route));

    p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !virt_sel |-> (rd_data[63:32] == '0 && rd_data[30:25] == '0));

    p_defer_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        defer_valid |=> (state_q.pend == HAS_SYNC_SRC));

    p_no_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.pend |-> HAS_SYNC_SRC);

endmodule

bind dsyn_reg_unit dsyn_reg_unit_chk #(
    .HAS_SYNC_SRC (HAS_SYNC_SRC)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_valid       (acc_valid),
    .acc_enc         (acc_enc),
    .acc_el          (acc_el),
    .hyp_enabled     (hyp_enabled),
    .hyp_abort_route (hyp_abort_route),
    .defer_valid     (defer_valid),
    .rd_data         (rd_data),
    .undef_trap      (undef_trap),
    .virt_sel        (virt_sel),
    .state_q         (state_q)
);

// File: tb/dsyn_reg_unit_test.sv
module dsyn_reg_unit_test;

    localparam logic [15:0] ENC   = 16'hC609;
    localparam logic [63:0] KNOWN = 64'h0000_0000_8000_1E3F;
    localparam logic [63:0] VIRT  = 64'h0BAD_F00D_1234_5678;

    // {write data, expected read-back}
    localparam logic [127:0] VEC [6] = '{
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_81FF_FFFF},
        {64'hFFFF_FFFF_FEFF_FFFF, 64'h0000_0000_8000_1E3F},
        {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        {64'h0000_0000_0100_0000, 64'h0000_0000_0100_0000},
        {64'h1234_5678_7E00_15C5, 64'h0000_0000_0000_1405},
        {64'h0000_0000_83AB_CDEF, 64'h0000_0000_81AB_CDEF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        defer_valid = 1'b0, defer_impl = 1'b0;
    logic [23:0] defer_syn = '0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [15:0] acc_enc = ENC;
    logic [63:0] acc_wdata = '0;
    logic [1:0]  acc_el = 2'd2;
    logic        hyp_enabled = 1'b0, hyp_abort_route = 1'b0;
    logic        mon_present = 1'b0, mon_ea_route = 1'b0, in_debug = 1'b0;
    logic [3:0]  razwi_el_mask = 4'b0000;
    logic [63:0] virt_rdata = VIRT;
    logic [63:0] rd_data, rd_data_ns;
    logic        undef_trap, virt_sel, undef_trap_ns, virt_sel_ns;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dsyn_reg_unit uut (
        .clk(clk), .rst_n(rst_n), .defer_valid(defer_valid), .defer_impl(defer_impl),
        .defer_syn(defer_syn), .acc_valid(acc_valid), .acc_enc(acc_enc),
        .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_el(acc_el),
        .hyp_enabled(hyp_enabled), .hyp_abort_route(hyp_abort_route),
        .mon_present(mon_present), .mon_ea_route(mon_ea_route), .in_debug(in_debug),
        .razwi_el_mask(razwi_el_mask), .virt_rdata(virt_rdata),
        .rd_data(rd_data), .undef_trap(undef_trap), .virt_sel(virt_sel)
    );

    dsyn_reg_unit #(.HAS_SYNC_SRC(1'b0)) uut_nosrc (
        .clk(clk), .rst_n(rst_n), .defer_valid(defer_valid), .defer_impl(defer_impl),
        .defer_syn(defer_syn), .acc_valid(acc_valid), .acc_enc(acc_enc),
        .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_el(acc_el),
        .hyp_enabled(hyp_enabled), .hyp_abort_route(hyp_abort_route),
        .mon_present(mon_present), .mon_ea_route(mon_ea_route), .in_debug(in_debug),
        .razwi_el_mask(razwi_el_mask), .virt_rdata(virt_rdata),
        .rd_data(rd_data_ns), .undef_trap(undef_trap_ns), .virt_sel(virt_sel_ns)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request at the falling edge; outputs settle 1 ns later,
    // the next rising edge commits any write.
    task automatic drive(input logic av, input logic [15:0] enc, input logic [1:0] el,
                         input logic wr, input logic [63:0] wd);
        @(negedge clk);
        defer_valid = 1'b0;
        acc_valid = av;
        acc_enc   = enc;
        acc_el    = el;
        acc_write = wr;
        acc_wdata = wd;
        #1;
    endtask

    task automatic defer_ev(input logic impl, input logic [23:0] syn);
        @(negedge clk);
        acc_valid   = 1'b0;
        acc_write   = 1'b0;
        defer_valid = 1'b1;
        defer_impl  = impl;
        defer_syn   = syn;
        #1;
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset state, nothing requested (R12)
        drive(0, ENC, 2'd2, 0, '0);
        chk("R12 idle rd_data", rd_data, '0);
        chk("R2 idle trap", {63'b0, undef_trap}, 64'd0);
        chk("R3 idle virt_sel", {63'b0, virt_sel}, 64'd0);

        // Layout table: write at level 2, read back (R7 R8 R9, R11 on second unit)
        for (int i = 0; i < 6; i++) begin
            drive(1, ENC, 2'd2, 1, VEC[i][127:64]);
            chk("R12 rd_data during write", rd_data, '0);
            drive(1, ENC, 2'd2, 0, '0);
            chk("R7/R8/R9 layout", rd_data, VEC[i][63:0]);
            chk("R11 layout no pend", rd_data_ns, VEC[i][63:0] & ~(64'd1 << 31));
        end

        drive(1, ENC, 2'd2, 1, KNOWN);
        // R1: other encoding
        drive(1, ENC ^ 16'h0001, 2'd2, 1, '0);
        drive(1, ENC, 2'd2, 0, '0);
        chk("R1 other enc write ignored", rd_data, KNOWN);
        drive(1, 16'hC608, 2'd0, 0, '0);
        chk("R1 other enc no trap", {63'b0, undef_trap}, 64'd0);
        chk("R1 other enc rd zero", rd_data, '0);

        // R2: level 0
        drive(1, ENC, 2'd0, 0, '0);
        chk("R2 el0 read trap", {63'b0, undef_trap}, 64'd1);
        chk("R2 el0 read zero", rd_data, '0);
        drive(1, ENC, 2'd0, 1, '0);
        chk("R2 el0 write trap", {63'b0, undef_trap}, 64'd1);
        drive(1, ENC, 2'd2, 0, '0);
        chk("R2 el0 write ignored", rd_data, KNOWN);

        // R3: virtual steering
        hyp_enabled = 1'b1; hyp_abort_route = 1'b1;
        drive(1, ENC, 2'd1, 0, '0);
        chk("R3 virt read", rd_data, VIRT);
        chk("R3 virt_sel", {63'b0, virt_sel}, 64'd1);
        drive(1, ENC, 2'd1, 1, '0);
        drive(1, ENC, 2'd2, 0, '0);
        chk("R3 virt write spares physical", rd_data, KNOWN);
        chk("R4 el2 ignores hyp route", {63'b0, virt_sel}, 64'd0);

        // R4: physical targets
        hyp_abort_route = 1'b0;
        drive(1, ENC, 2'd1, 0, '0);
        chk("R4 el1 no route reads physical", rd_data, KNOWN);
        chk("R4 el1 no route virt_sel", {63'b0, virt_sel}, 64'd0);
        hyp_enabled = 1'b0; hyp_abort_route = 1'b1;
        drive(1, ENC, 2'd3, 1, 64'h0000_0000_0100_0042);
        drive(1, ENC, 2'd1, 0, '0);
        chk("R4 el3 write / el1 read", rd_data, 64'h0000_0000_0100_0042);
        drive(1, ENC, 2'd1, 1, KNOWN);
        drive(1, ENC, 2'd3, 0, '0);
        chk("R4 el1 write / el3 read", rd_data, KNOWN);
        hyp_abort_route = 1'b0;

        // R5: monitor read-as-zero / write-ignored
        mon_present = 1'b1; mon_ea_route = 1'b1; razwi_el_mask = 4'b0110;
        drive(1, ENC, 2'd2, 0, '0);
        chk("R5 razwi read zero", rd_data, '0);
        drive(1, ENC, 2'd2, 1, '0);
        drive(1, ENC, 2'd3, 0, '0);
        chk("R5 razwi write dropped / unmasked level", rd_data, KNOWN);
        in_debug = 1'b1;
        drive(1, ENC, 2'd2, 0, '0);
        chk("R5 debug state disables razwi", rd_data, KNOWN);
        in_debug = 1'b0; mon_present = 1'b0;
        drive(1, ENC, 2'd2, 0, '0);
        chk("R5 no monitor disables razwi", rd_data, KNOWN);
        mon_ea_route = 1'b0; razwi_el_mask = 4'b0000;

        // R6 R8 R11: barrier capture, read next cycle
        defer_ev(1'b1, 24'h123456);
        drive(1, ENC, 2'd2, 0, '0);
        chk("R6/R8 defer impl visible", rd_data, 64'h0000_0000_8112_3456);
        chk("R11 defer no pend", rd_data_ns, 64'h0000_0000_0112_3456);
        defer_ev(1'b0, 24'hFFFFFF);
        drive(1, ENC, 2'd2, 0, '0);
        chk("R6/R7 defer architected", rd_data, 64'h0000_0000_8000_1E3F);
        chk("R11 defer architected no pend", rd_data_ns, 64'h0000_0000_0000_1E3F);

        // R10: barrier and write together
        @(negedge clk);
        defer_valid = 1'b1; defer_impl = 1'b1; defer_syn = 24'h00000A;
        acc_valid = 1'b1; acc_enc = ENC; acc_el = 2'd2; acc_write = 1'b1; acc_wdata = '0;
        drive(1, ENC, 2'd2, 0, '0);
        chk("R10 barrier beats write", rd_data, 64'h0000_0000_8100_000A);
        chk("R10 barrier beats write no pend", rd_data_ns, 64'h0000_0000_0100_000A);

        drive(0, ENC, 2'd2, 0, '0);
        chk("R12 idle after tests", rd_data, '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule